// File: doc/BRIEF.md
# Gapped Texture Copy DMA

This block is a raw copy engine for the texture-copy mode of a display-transfer unit. It moves a programmed number of 16-byte granules from a source region to a destination region. It does no format conversion, scaling or tiling. The source is read as runs of a programmable number of granules, and a programmable number of granules is skipped after each run. The destination is written the same way, using its own run length and its own skip length. The two sides keep their run boundaries separately, so one source run may feed several destination runs, and one destination run may be fed by several source runs.

Software programs the engine through a small word-wide register write port. A write to the launch register starts a transfer. The engine then steps through four states. IDLE waits for a launch. READ drives one source read. WRITE stores the returned granule at the destination. FINISH marks completion.

The transitions are:
- IDLE to READ on an accepted launch with a non-zero granule count.
- IDLE to FINISH on an accepted launch with a zero granule count.
- READ to WRITE always.
- WRITE back to READ while granules remain.
- WRITE to FINISH after the last granule.
- FINISH to IDLE always.

The memory side has a read port with one cycle of latency and a write port that never stalls.

Register offsets on `cfg_addr`:

| Offset | Register | Contents |
|--------|----------|----------|
| 0 | source address | byte address divided by 8 |
| 1 | destination address | byte address divided by 8 |
| 2 | total size | byte count |
| 3 | source shape | run length in bits [15:0], gap in bits [31:16], both in granules |
| 4 | destination shape | same layout as the source shape |
| 5 | mode | copy-mode enable in bit 3 |
| 6 | launch | any write triggers a launch |

Top module: `gapped_copy_dma`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `rd_en`, `wr_en` and `done_pulse` are all low.
- R2: A launch write (offset 6) issued in IDLE, with mode bit 3 set and both run lengths non-zero, starts a transfer. In the next cycle `busy` is high and `done` is low. A launch while mode bit 3 is clear is ignored: there is no memory access, and `busy`, `done` and `err` keep their values.
- R3: The first source read goes to the source address register times 8. The first destination write goes to the destination address register times 8.
- R4: The low 4 bits of the total size are ignored, and the granule count is size >> 4. When that count is zero, the transfer completes with no memory access.
- R5: Source granule k is read at source base + 16·((k / Ws)·(Ws + Gs) + k mod Ws). Ws is the source run length and Gs is the source gap.
- R6: Destination granule k is written at destination base + 16·((k / Wd)·(Wd + Gd) + k mod Wd). This holds independently of the source shape.
- R7: Each written granule carries the data returned for the matching source read. Exactly count reads and count writes are made.
- R8: A launch with copy mode set and a zero run length on either side sets `err` and makes no memory access. The next accepted launch clears `err`.
- R9: `done_pulse` is high for exactly one cycle per transfer. In the following cycle, `busy` is low and `done` is high. `done` stays high until the next accepted launch.
- R10: A launch while busy is ignored. Register writes during a transfer do not change the transfer in progress.
- R11: Each read is followed in the next cycle by its write, and reads and writes never overlap. A transfer of N granules raises `done_pulse` 2N+1 cycles after the launch edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| rd_en | output | 1 | Source read request |
| rd_addr | output | 32 | Source byte address |
| rd_data | input | 128 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | 32 | Destination byte address |
| wr_data | output | 128 | Destination write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky zero-run-length error flag |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume a memory that returns read data exactly one cycle after `rd_en` and accepts every write at once. The bench memory model does exactly that: it answers each read with a pattern derived from the read address, so every written granule shows which source location it came from. The assertions also assume that reset is applied before the first launch. The bench holds reset for several cycles and then issues register writes only on falling edges, one at a time. This keeps every launch and every mid-transfer poke on a known cycle relative to the state sequence.

// File: rtl/gtc_pkg.sv
`timescale 1ns/1ps
package gtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } gtc_state_e;

    localparam int unsigned REG_SRC_ADDR  = 0;
    localparam int unsigned REG_DST_ADDR  = 1;
    localparam int unsigned REG_TOTAL     = 2;
    localparam int unsigned REG_SRC_SHAPE = 3;
    localparam int unsigned REG_DST_SHAPE = 4;
    localparam int unsigned REG_MODE      = 5;
    localparam int unsigned REG_LAUNCH    = 6;
    localparam int unsigned NUM_STORED    = 6;

    localparam int unsigned MODE_COPY_BIT = 3;

endpackage

// File: rtl/gtc_cfg_regs.sv
`timescale 1ns/1ps
module gtc_cfg_regs
    import gtc_pkg::*;
#(
    parameter int unsigned REG_W  = 32,
    parameter int unsigned CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  src_addr_raw,
    output logic [REG_W-1:0]  dst_addr_raw,
    output logic [REG_W-1:0]  total_size,
    output logic [REG_W-1:0]  src_shape,
    output logic [REG_W-1:0]  dst_shape,
    output logic [REG_W-1:0]  mode_word,
    output logic              launch
);

    logic [NUM_STORED-1:0][REG_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < NUM_STORED; i++) begin
                if (cfg_we && (cfg_addr == CFG_AW'(i))) begin
                    regs_q[i] <= cfg_wdata;
                end
            end
        end
    end

    assign launch       = cfg_we && (cfg_addr == CFG_AW'(REG_LAUNCH));
    assign src_addr_raw = regs_q[REG_SRC_ADDR];
    assign dst_addr_raw = regs_q[REG_DST_ADDR];
    assign total_size   = regs_q[REG_TOTAL];
    assign src_shape    = regs_q[REG_SRC_SHAPE];
    assign dst_shape    = regs_q[REG_DST_SHAPE];
    assign mode_word    = regs_q[REG_MODE];

endmodule

// File: rtl/gtc_walker.sv
`timescale 1ns/1ps
module gtc_walker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned FIELD_W    = 16,
    parameter int unsigned GRAN_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  base,
    input  logic [FIELD_W-1:0] width,
    input  logic [FIELD_W-1:0] gap,
    input  logic               step,
    output logic [ADDR_W-1:0]  addr
);

    localparam logic [ADDR_W-1:0]  GRAN_INC = ADDR_W'(1) << GRAN_SHIFT;
    localparam logic [FIELD_W-1:0] CNT_ONE  = FIELD_W'(1);

    logic [ADDR_W-1:0]  addr_q;
    logic [FIELD_W-1:0] width_q;
    logic [FIELD_W-1:0] gap_q;
    logic [FIELD_W-1:0] run_q;
    logic               run_last;
    logic [ADDR_W-1:0]  skip_bytes;

    assign run_last   = ((run_q + CNT_ONE) == width_q);
    assign skip_bytes = ADDR_W'(gap_q) << GRAN_SHIFT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            width_q <= '0;
            gap_q   <= '0;
            run_q   <= '0;
        end else if (load) begin
            addr_q  <= base;
            width_q <= width;
            gap_q   <= gap;
            run_q   <= '0;
        end else if (step) begin
            if (run_last) begin
                addr_q <= addr_q + GRAN_INC + skip_bytes;
                run_q  <= '0;
            end else begin
                addr_q <= addr_q + GRAN_INC;
                run_q  <= run_q + CNT_ONE;
            end
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/gtc_ctrl.sv
`timescale 1ns/1ps
module gtc_ctrl
    import gtc_pkg::*;
#(
    parameter int unsigned CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             copy_mode,
    input  logic             shape_bad,
    input  logic [CNT_W-1:0] gran_total,
    output logic             load,
    output logic             rd_en,
    output logic             wr_en,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             done_pulse
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    gtc_state_e       state_q, state_d;
    logic [CNT_W-1:0] rem_q;
    logic             done_q, err_q;
    logic             launch_idle, accept, reject, last_beat;

    assign launch_idle = launch && (state_q == ST_IDLE) && copy_mode;
    assign accept      = launch_idle && !shape_bad;
    assign reject      = launch_idle && shape_bad;
    assign last_beat   = (rem_q == CNT_ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = (gran_total == '0) ? ST_FINISH : ST_READ;
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = last_beat ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (accept)                  rem_q <= gran_total;
            else if (state_q == ST_WRITE) rem_q <= rem_q - CNT_ONE;

            if (accept)                    done_q <= 1'b0;
            else if (state_q == ST_FINISH) done_q <= 1'b1;

            if (accept)      err_q <= 1'b0;
            else if (reject) err_q <= 1'b1;
        end
    end

    always_comb begin
        load       = accept;
        rd_en      = 1'b0;
        wr_en      = 1'b0;
        done_pulse = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy       = 1'b0;
            ST_READ:   rd_en      = 1'b1;
            ST_WRITE:  wr_en      = 1'b1;
            ST_FINISH: done_pulse = 1'b1;
            default:   busy       = 1'b0;
        endcase
    end

    assign done = done_q;
    assign err  = err_q;

endmodule

// File: rtl/gapped_copy_dma.sv
`timescale 1ns/1ps
module gapped_copy_dma
    import gtc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned REG_W      = 32,
    parameter int unsigned FIELD_W    = 16,
    parameter int unsigned GRAN_BYTES = 16,
    parameter int unsigned ADDR_SCALE = 8,
    parameter int unsigned CFG_AW     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [REG_W-1:0]        cfg_wdata,
    output logic                    rd_en,
    output logic [ADDR_W-1:0]       rd_addr,
    input  logic [GRAN_BYTES*8-1:0] rd_data,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [GRAN_BYTES*8-1:0] wr_data,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic                    done_pulse
);

    localparam int unsigned GRAN_SHIFT  = $clog2(GRAN_BYTES);
    localparam int unsigned SCALE_SHIFT = $clog2(ADDR_SCALE);
    localparam int unsigned CNT_W       = REG_W - GRAN_SHIFT;
    localparam int unsigned NUM_SIDES   = 2;

    logic [REG_W-1:0] src_raw, dst_raw, total_q, src_shape_q, dst_shape_q, mode_q;
    logic             launch, load;

    gtc_cfg_regs #(.REG_W(REG_W), .CFG_AW(CFG_AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .src_addr_raw (src_raw),
        .dst_addr_raw (dst_raw),
        .total_size   (total_q),
        .src_shape    (src_shape_q),
        .dst_shape    (dst_shape_q),
        .mode_word    (mode_q),
        .launch       (launch)
    );

    logic [NUM_SIDES-1:0][REG_W-1:0]   side_raw, side_shape;
    logic [NUM_SIDES-1:0][ADDR_W-1:0]  side_base, side_addr;
    logic [NUM_SIDES-1:0][FIELD_W-1:0] side_width, side_gap;
    logic [NUM_SIDES-1:0]              side_step;

    assign side_raw[0]   = src_raw;
    assign side_raw[1]   = dst_raw;
    assign side_shape[0] = src_shape_q;
    assign side_shape[1] = dst_shape_q;
    assign side_step[0]  = rd_en;
    assign side_step[1]  = wr_en;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        assign side_base[s]  = ADDR_W'({side_raw[s], {SCALE_SHIFT{1'b0}}});
        assign side_width[s] = side_shape[s][FIELD_W-1:0];
        assign side_gap[s]   = side_shape[s][2*FIELD_W-1:FIELD_W];

        gtc_walker #(
            .ADDR_W    (ADDR_W),
            .FIELD_W   (FIELD_W),
            .GRAN_SHIFT(GRAN_SHIFT)
        ) u_walker (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .base  (side_base[s]),
            .width (side_width[s]),
            .gap   (side_gap[s]),
            .step  (side_step[s]),
            .addr  (side_addr[s])
        );
    end

    logic             shape_bad;
    logic [CNT_W-1:0] gran_total;
    logic             unused_bits;

    assign shape_bad   = (side_width[0] == '0) || (side_width[1] == '0);
    assign gran_total  = total_q[REG_W-1:GRAN_SHIFT];
    assign unused_bits = ^{mode_q, total_q[GRAN_SHIFT-1:0], src_shape_q, dst_shape_q};

    gtc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .copy_mode  (mode_q[MODE_COPY_BIT]),
        .shape_bad  (shape_bad),
        .gran_total (gran_total),
        .load       (load),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .done_pulse (done_pulse)
    );

    assign rd_addr = side_addr[0];
    assign wr_addr = side_addr[1];
    assign wr_data = rd_data;

endmodule

// File: rtl/gtc_checker.sv
`timescale 1ns/1ps
module gtc_checker (
    input logic clk,
    input logic rst_n,
    input logic rd_en,
    input logic wr_en,
    input logic busy,
    input logic done,
    input logic err,
    input logic done_pulse
);

    // R11
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> wr_en);

    // R11
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en));

    // R11
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_en, wr_en, done_pulse}));

    // R9
    done_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (done && !busy));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

endmodule

bind gapped_copy_dma gtc_checker u_gtc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .done_pulse (done_pulse)
);

// File: tb/gapped_copy_dma_tb_top.sv
`timescale 1ns/1ps
module gapped_copy_dma_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_we;
    logic [2:0]   cfg_addr;
    logic [31:0]  cfg_wdata;
    logic         rd_en, wr_en, busy, done, err, done_pulse;
    logic [31:0]  rd_addr, wr_addr;
    logic [127:0] rd_data, wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int pulse_cnt = 0;
    bit finished = 1'b0;
    logic [31:0]  log_addr [0:1023];
    logic [127:0] log_data [0:1023];

    always #10 clk = ~clk;

    gapped_copy_dma dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .err(err), .done_pulse(done_pulse)
    );

    function automatic logic [127:0] pat(input logic [31:0] a);
        return {a ^ 32'h5A5A_0000, ~a, a + 32'd7, a};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] raw, input int w, input int g, input int k);
        return (raw << 3) + 32'(((k / w) * (w + g) + (k % w)) * 16);
    endfunction

    always @(posedge clk) if (rd_en) rd_data <= pat(rd_addr);

    always @(negedge clk) begin
        if (rd_en) rd_cnt++;
        if (wr_en) begin
            log_addr[wr_cnt % 1024] = wr_addr;
            log_data[wr_cnt % 1024] = wr_data;
            wr_cnt++;
        end
        if (done_pulse) pulse_cnt++;
    end

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_xfer(input logic [31:0] sraw, input logic [31:0] draw, input logic [31:0] size,
                            input int sw, input int sg, input int dw, input int dg, input bit poke);
        int n, cyc, r0, w0, p0;
        n = int'(size >> 4);
        wr_cfg(3'd0, sraw);
        wr_cfg(3'd1, draw);
        wr_cfg(3'd2, size);
        wr_cfg(3'd3, {sg[15:0], sw[15:0]});
        wr_cfg(3'd4, {dg[15:0], dw[15:0]});
        wr_cfg(3'd5, 32'h8);
        #1; r0 = rd_cnt; w0 = wr_cnt; p0 = pulse_cnt;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_we = 1'b0; cyc = 1;
        chk("R2 start", {158'd0, done, busy}, 160'b01);
        while (!done_pulse && cyc < 1000) begin
            if (poke && cyc == 3) begin cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h777; end
            else if (poke && cyc == 4) cfg_addr = 3'd6;
            else if (poke && cyc == 5) cfg_we = 1'b0;
            @(negedge clk); cyc++;
        end
        cfg_we = 1'b0;
        chk("R11 latency", 160'(cyc), 160'(2 * n + 1));
        @(negedge clk);
        chk("R9 end flags", {157'd0, done_pulse, done, busy}, 160'b010);
        #1;
        chk("R7 reads", 160'(rd_cnt - r0), 160'(n));
        chk("R7 writes", 160'(wr_cnt - w0), 160'(n));
        chk(poke ? "R10 pulses" : "R9 pulses", 160'(pulse_cnt - p0), 160'd1);
        for (int k = 0; k < n; k++) begin
            chk(k == 0 ? "R3 dst" : "R6 dst", 160'(log_addr[(w0 + k) % 1024]), 160'(exp_addr(draw, dw, dg, k)));
            chk(k == 0 ? "R3 src" : (poke ? "R10 src" : "R5 src"),
                160'(log_data[(w0 + k) % 1024]), 160'(pat(exp_addr(sraw, sw, sg, k))));
        end
    endtask

    task automatic launch_only(output int reads);
        int r0;
        #1; r0 = rd_cnt;
        wr_cfg(3'd6, 32'h0);
        repeat (6) @(negedge clk);
        #1; reads = rd_cnt - r0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int reads;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        chk("R1 reset", {154'd0, busy, done, err, rd_en, wr_en, done_pulse}, 160'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", {154'd0, busy, done, err, rd_en, wr_en, done_pulse}, 160'd0);

        // R4: size below one granule, then low bits ignored
        run_xfer(32'h0000_0200, 32'h0000_0800, 32'd15, 2, 1, 2, 1, 1'b0);
        run_xfer(32'h0000_0201, 32'h0000_0803, 32'd57, 2, 1, 1, 3, 1'b0);

        // R5 R6 R3: sweep of run lengths and gaps on both sides
        for (int sw = 1; sw <= 3; sw++)
            for (int sg = 0; sg <= 2; sg++)
                for (int dw = 1; dw <= 3; dw++)
                    for (int dg = 0; dg <= 2; dg++)
                        run_xfer(32'h100 + 32'(sw * 17 + sg), 32'h4000 + 32'(dw * 5 + dg * 3),
                                 32'((4 + (sw + dg) % 3) * 16 + (sw * 3) % 16), sw, sg, dw, dg, 1'b0);

        // R10: launch and address rewrite while busy
        run_xfer(32'h0000_0321, 32'h0000_0655, 32'd96, 2, 3, 3, 1, 1'b1);

        // R2: copy-mode bit clear, launch ignored
        wr_cfg(3'd5, 32'hFFFF_FFF7);
        launch_only(reads);
        chk("R2 ignored", {156'd0, busy, done, err, reads != 0}, 160'b0100);

        // R8: zero source run length
        wr_cfg(3'd5, 32'h8);
        wr_cfg(3'd3, 32'h0005_0000);
        launch_only(reads);
        chk("R8 src zero", {157'd0, busy, err, reads != 0}, 160'b010);

        // R8: good launch clears err
        run_xfer(32'h0000_0040, 32'h0000_0090, 32'd32, 1, 0, 1, 0, 1'b0);
        chk("R8 cleared", {159'd0, err}, 160'd0);

        // R8: zero destination run length
        wr_cfg(3'd4, 32'h0002_0000);
        launch_only(reads);
        chk("R8 dst zero", {157'd0, busy, err, reads != 0}, 160'b010);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule